// File: doc/BRIEF.md
# Command Stream Register-Write Decoder

This block sits behind a command queue and turns a stream of 32-bit command words into register-write transactions. Each transaction carries a 10-bit class, a 12-bit register offset and 32 bits of data. A header word names an opcode in its top nibble. The decoder then consumes the payload words that the header announces and gives each one a target offset. Payload addressing is one of three kinds: incrementing, fixed, or mask-selected. Commands that are not register writes come out on sideband event ports: a restart address, a gather descriptor with its address, lock acquire or release, and unknown extended commands.

Words arrive through a valid/ready handshake. `in_last` marks the final word of a stream. Each accepted word produces its outputs as single-cycle pulses on the clock edge after acceptance. Fetching gather memory, arbitrating locks and holding the target registers are left to neighbouring blocks.

The controller has three states. `S_HEADER` decodes a header. `S_PAYLOAD` consumes write payload. `S_GADDR` takes the single gather address word. The transitions are as follows:
- HEADER→PAYLOAD on a header that announces at least one payload word.
- HEADER→GADDR on a gather header.
- PAYLOAD→HEADER when the last announced word is taken.
- GADDR→HEADER on the address word.
- Any state→HEADER on a word flagged `in_last`.

Top module: `cmd_stream_decoder`

## Requirements
- R1: While reset is high and on the first edge after it, every output pulse (`wr_valid`, `rs_valid`, `ga_valid`, `lk_valid`, `ext_unknown`, `trunc_err`) is low. Once reset is released, `in_ready` is high and the decoder waits for a header.
- R2: Opcode 0x0 (class set) loads bits [15:6] of the header as the current class. If mask bits [5:0] are zero, the header has no payload and the next word is a header.
- R3: Opcode 0x0 with a nonzero mask is followed by as many payload words as the mask has set bits. The k-th word is written, under the new class, to offset (bits [27:16]) plus the index of the k-th set mask bit, counted from bit 0 upward.
- R4: Opcode 0x1 announces bits [15:0] payload words. They are written to offset, offset+1, and so on, and the offset wraps modulo 4096.
- R5: Opcode 0x2 announces bits [15:0] payload words. All of them are written to the same offset, bits [27:16].
- R6: Opcode 0x3 announces as many payload words as the 16-bit mask in bits [15:0] has set bits. Each word goes to offset plus the next set mask bit index, in ascending order.
- R7: Opcode 0x4 carries no payload. It writes bits [15:0], zero-extended, to offset bits [27:16] under the current class.
- R8: Opcode 0x5 carries no payload. It emits a restart event whose address is the header shifted left by 4 bits.
- R9: Opcode 0x6 is followed by exactly one address word. That word is not decoded. It emits a gather event carrying the header's offset [27:16], insert flag bit 15, type flag bit 14, count [13:0], and the address.
- R10: Opcode 0xE reads a sub-opcode from bits [27:24]. Sub-op 0 emits a lock acquire and sub-op 1 a lock release, each with index bits [7:0]. Every other sub-op emits `ext_unknown`.
- R11: Opcodes 0x7 to 0xD and 0xF produce no output and no payload. The next word is a header.
- R12: An opcode 0x1 or 0x2 header with a zero count has no payload, so the next word is decoded as a header.
- R13: A word accepted with `in_last` while more payload would still be expected afterwards raises `trunc_err` for one cycle, and the decoder returns to `S_HEADER`. A stream whose last word completes its payload raises no error.
- R14: Outputs pulse exactly one cycle after the accepting edge. A cycle without `in_valid` produces no output and keeps the payload position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Command word present |
| in_ready | output | 1 | Decoder accepts a word |
| in_data | input | 32 | Command word |
| in_last | input | 1 | Final word of the stream |
| wr_valid | output | 1 | Register write pulse |
| wr_class | output | 10 | Class of the write |
| wr_offset | output | 12 | Register offset of the write |
| wr_data | output | 32 | Write data |
| rs_valid | output | 1 | Restart event pulse |
| rs_addr | output | 32 | Restart address |
| ga_valid | output | 1 | Gather event pulse |
| ga_offset | output | 12 | Gather target offset |
| ga_insert | output | 1 | Gather insert flag |
| ga_type | output | 1 | Gather type flag |
| ga_count | output | 14 | Gather word count |
| ga_addr | output | 32 | Gather address |
| lk_valid | output | 1 | Lock event pulse |
| lk_release | output | 1 | 1 = release, 0 = acquire |
| lk_index | output | 8 | Lock index |
| ext_unknown | output | 1 | Unrecognised extended sub-op pulse |
| trunc_err | output | 1 | Stream ended inside a payload |

## Verification
The bench targets several corner cases, and each one shows up as a specific wrong output:
- An incrementing run that crosses offset 0xFFF. A decoder without 12-bit wrap would write outside the offset range.
- Sparse masks such as 0x8001 and 0b101001. A decoder that walked the mask in the wrong order, or counted words instead of bits, would write to the wrong offsets.
- A zero-count header. A wrong design would swallow the next header as data.
- The gather address word and unknown opcodes. A wrong design would decode these as commands.
- Streams cut off mid-payload and mid-gather, and a stream that ends exactly on its final payload word. These separate a missing error from a spurious one.
- An idle gap inside a payload. A decoder that advanced without a handshake would lose or duplicate an offset.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
    localparam int WORD_W  = 32;
    localparam int CLS_W   = 10;
    localparam int OFS_W   = 12;
    localparam int CNT_W   = 16;
    localparam int MASK_W  = 16;
    localparam int SMASK_W = 6;
    localparam int GCNT_W  = 14;
    localparam int LIDX_W  = 8;
    localparam int OP_W    = 4;

    localparam logic [OP_W-1:0] OP_SETCL   = 4'h0;
    localparam logic [OP_W-1:0] OP_INCR    = 4'h1;
    localparam logic [OP_W-1:0] OP_NONINCR = 4'h2;
    localparam logic [OP_W-1:0] OP_MASK    = 4'h3;
    localparam logic [OP_W-1:0] OP_IMM     = 4'h4;
    localparam logic [OP_W-1:0] OP_RESTART = 4'h5;
    localparam logic [OP_W-1:0] OP_GATHER  = 4'h6;
    localparam logic [OP_W-1:0] OP_EXTEND  = 4'hE;

    localparam logic [3:0] SUB_ACQUIRE = 4'h0;
    localparam logic [3:0] SUB_RELEASE = 4'h1;

    typedef enum logic [1:0] {
        S_HEADER  = 2'd0,
        S_PAYLOAD = 2'd1,
        S_GADDR   = 2'd2
    } dec_state_e;

    typedef enum logic [1:0] {
        M_INCR    = 2'd0,
        M_NONINCR = 2'd1,
        M_MASKED  = 2'd2
    } addr_mode_e;
endpackage

// File: rtl/cmd_word_split.sv
module cmd_word_split
    import cmd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [OP_W-1:0]   op,
    output logic [OFS_W-1:0]  ofs,
    output logic [CLS_W-1:0]  cls,
    output logic [MASK_W-1:0] cls_mask,
    output logic [MASK_W-1:0] low16,
    output logic [3:0]        sub,
    output logic [LIDX_W-1:0] lidx
);
    assign op       = word[31:28];
    assign ofs      = word[27:16];
    assign cls      = word[15:6];
    assign cls_mask = {{(MASK_W-SMASK_W){1'b0}}, word[SMASK_W-1:0]};
    assign low16    = word[15:0];
    assign sub      = word[27:24];
    assign lidx     = word[LIDX_W-1:0];
endmodule

// File: rtl/cmd_mask_pick.sv
module cmd_mask_pick #(
    parameter int W = 16,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     mask,
    output logic [IDX_W-1:0] idx,
    output logic [W-1:0]     rest,
    output logic             rest_empty
);
    logic [W-1:0] lowest;

    always_comb begin
        logic seen;
        seen   = 1'b0;
        lowest = '0;
        idx    = '0;
        for (int i = 0; i < W; i++) begin
            if (mask[i] && !seen) begin
                lowest[i] = 1'b1;
                idx       = IDX_W'(i);
                seen      = 1'b1;
            end
        end
    end

    assign rest       = mask & ~lowest;
    assign rest_empty = (rest == '0);
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
    import cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    output logic              wr_valid,
    output logic [CLS_W-1:0]  wr_class,
    output logic [OFS_W-1:0]  wr_offset,
    output logic [WORD_W-1:0] wr_data,
    output logic              rs_valid,
    output logic [WORD_W-1:0] rs_addr,
    output logic              ga_valid,
    output logic [OFS_W-1:0]  ga_offset,
    output logic              ga_insert,
    output logic              ga_type,
    output logic [GCNT_W-1:0] ga_count,
    output logic [WORD_W-1:0] ga_addr,
    output logic              lk_valid,
    output logic              lk_release,
    output logic [LIDX_W-1:0] lk_index,
    output logic              ext_unknown,
    output logic              trunc_err
);
    localparam int IDX_W  = $clog2(MASK_W);
    localparam int GHDR_W = OFS_W + 2 + GCNT_W;

    dec_state_e state_q, state_d;
    addr_mode_e mode_q;
    logic [CLS_W-1:0]  class_q;
    logic [OFS_W-1:0]  base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [MASK_W-1:0] mask_q;
    logic [GHDR_W-1:0] ghdr_q;
    logic              ready_q;
    logic              wr_pay_q;
    addr_mode_e        wr_mode_q;

    logic [OP_W-1:0]   h_op;
    logic [OFS_W-1:0]  h_ofs;
    logic [CLS_W-1:0]  h_cls;
    logic [MASK_W-1:0] h_cmask;
    logic [MASK_W-1:0] h_low;
    logic [3:0]        h_sub;
    logic [LIDX_W-1:0] h_lidx;

    logic [IDX_W-1:0]  pick_idx;
    logic [MASK_W-1:0] pick_rest;
    logic              pick_empty;

    logic fire, trunc;

    cmd_word_split u_split (
        .word     (in_data),
        .op       (h_op),
        .ofs      (h_ofs),
        .cls      (h_cls),
        .cls_mask (h_cmask),
        .low16    (h_low),
        .sub      (h_sub),
        .lidx     (h_lidx)
    );

    cmd_mask_pick #(.W(MASK_W)) u_pick (
        .mask       (mask_q),
        .idx        (pick_idx),
        .rest       (pick_rest),
        .rest_empty (pick_empty)
    );

    assign in_ready = ready_q;
    assign fire     = in_valid && ready_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (fire) begin
            unique case (state_q)
                S_HEADER: begin
                    if (h_op == OP_SETCL && h_cmask != '0)
                        state_d = S_PAYLOAD;
                    else if ((h_op == OP_INCR || h_op == OP_NONINCR) && h_low != '0)
                        state_d = S_PAYLOAD;
                    else if (h_op == OP_MASK && h_low != '0)
                        state_d = S_PAYLOAD;
                    else if (h_op == OP_GATHER)
                        state_d = S_GADDR;
                end
                S_PAYLOAD: begin
                    if (mode_q == M_MASKED) begin
                        if (pick_empty) state_d = S_HEADER;
                    end else if (cnt_q == CNT_W'(1)) begin
                        state_d = S_HEADER;
                    end
                end
                S_GADDR: state_d = S_HEADER;
                default: state_d = S_HEADER;
            endcase
        end
        trunc = fire && in_last && (state_d != S_HEADER);
        if (trunc) state_d = S_HEADER;
    end

    // state register and payload bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_HEADER;
            mode_q  <= M_INCR;
            class_q <= '0;
            base_q  <= '0;
            cnt_q   <= '0;
            mask_q  <= '0;
            ghdr_q  <= '0;
            ready_q <= 1'b0;
        end else begin
            ready_q <= 1'b1;
            state_q <= state_d;
            if (fire) begin
                unique case (state_q)
                    S_HEADER: begin
                        base_q <= h_ofs;
                        if (h_op == OP_SETCL) begin
                            class_q <= h_cls;
                            mode_q  <= M_MASKED;
                            mask_q  <= h_cmask;
                        end else if (h_op == OP_INCR) begin
                            mode_q <= M_INCR;
                            cnt_q  <= h_low;
                        end else if (h_op == OP_NONINCR) begin
                            mode_q <= M_NONINCR;
                            cnt_q  <= h_low;
                        end else if (h_op == OP_MASK) begin
                            mode_q <= M_MASKED;
                            mask_q <= h_low;
                        end else if (h_op == OP_GATHER) begin
                            ghdr_q <= in_data[GHDR_W-1:0];
                        end
                    end
                    S_PAYLOAD: begin
                        if (mode_q == M_MASKED) begin
                            mask_q <= pick_rest;
                        end else begin
                            cnt_q <= cnt_q - CNT_W'(1);
                            if (mode_q == M_INCR) base_q <= base_q + OFS_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid    <= 1'b0;
            wr_class    <= '0;
            wr_offset   <= '0;
            wr_data     <= '0;
            wr_pay_q    <= 1'b0;
            wr_mode_q   <= M_INCR;
            rs_valid    <= 1'b0;
            rs_addr     <= '0;
            ga_valid    <= 1'b0;
            ga_offset   <= '0;
            ga_insert   <= 1'b0;
            ga_type     <= 1'b0;
            ga_count    <= '0;
            ga_addr     <= '0;
            lk_valid    <= 1'b0;
            lk_release  <= 1'b0;
            lk_index    <= '0;
            ext_unknown <= 1'b0;
            trunc_err   <= 1'b0;
        end else begin
            wr_valid    <= 1'b0;
            wr_pay_q    <= 1'b0;
            rs_valid    <= 1'b0;
            ga_valid    <= 1'b0;
            lk_valid    <= 1'b0;
            ext_unknown <= 1'b0;
            trunc_err   <= trunc;
            if (fire) begin
                unique case (state_q)
                    S_HEADER: begin
                        if (h_op == OP_IMM) begin
                            wr_valid  <= 1'b1;
                            wr_class  <= class_q;
                            wr_offset <= h_ofs;
                            wr_data   <= {{(WORD_W-MASK_W){1'b0}}, h_low};
                        end else if (h_op == OP_RESTART) begin
                            rs_valid <= 1'b1;
                            rs_addr  <= {in_data[WORD_W-5:0], 4'b0000};
                        end else if (h_op == OP_EXTEND) begin
                            if (h_sub == SUB_ACQUIRE || h_sub == SUB_RELEASE) begin
                                lk_valid   <= 1'b1;
                                lk_release <= (h_sub == SUB_RELEASE);
                                lk_index   <= h_lidx;
                            end else begin
                                ext_unknown <= 1'b1;
                            end
                        end
                    end
                    S_PAYLOAD: begin
                        wr_valid  <= 1'b1;
                        wr_pay_q  <= 1'b1;
                        wr_mode_q <= mode_q;
                        wr_class  <= class_q;
                        wr_offset <= (mode_q == M_MASKED) ? base_q + OFS_W'(pick_idx) : base_q;
                        wr_data   <= in_data;
                    end
                    S_GADDR: begin
                        ga_valid  <= 1'b1;
                        ga_offset <= ghdr_q[GHDR_W-1 -: OFS_W];
                        ga_insert <= ghdr_q[GCNT_W+1];
                        ga_type   <= ghdr_q[GCNT_W];
                        ga_count  <= ghdr_q[GCNT_W-1:0];
                        ga_addr   <= in_data;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R14: a cycle with no accepted word yields no pulse on the next edge
    p_quiet_idle_r14: assert property (@(posedge clk) disable iff (rst)
        $past(!(in_valid && in_ready)) |-> !(wr_valid || rs_valid || ga_valid || lk_valid || ext_unknown));

    // R4: consecutive incrementing payload writes step the offset by one
    p_incr_step_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_pay_q && wr_mode_q == M_INCR &&
         $past(wr_valid && wr_pay_q && wr_mode_q == M_INCR)) |-> wr_offset == $past(wr_offset) + OFS_W'(1));

    // R5: consecutive fixed-address payload writes keep the offset
    p_fixed_ofs_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_pay_q && wr_mode_q == M_NONINCR &&
         $past(wr_valid && wr_pay_q && wr_mode_q == M_NONINCR)) |-> wr_offset == $past(wr_offset));

    // R8: restart address is word aligned to 16 bytes
    p_restart_align_r8: assert property (@(posedge clk) disable iff (rst)
        rs_valid |-> rs_addr[3:0] == 4'b0000);

    // R9: after the gather address the decoder waits for a header
    p_gather_done_r9: assert property (@(posedge clk) disable iff (rst)
        ga_valid |-> state_q == S_HEADER);

    // R13: a truncation always leaves the decoder at a header boundary
    p_trunc_home_r13: assert property (@(posedge clk) disable iff (rst)
        trunc_err |-> state_q == S_HEADER);
endmodule

// File: tb/cmd_stream_decoder_bench.sv
module cmd_stream_decoder_bench;
    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] K_WR = 3'd1;
    localparam logic [2:0] K_RS = 3'd2;
    localparam logic [2:0] K_GA = 3'd3;
    localparam logic [2:0] K_LK = 3'd4;
    localparam logic [2:0] K_UN = 3'd5;
    localparam logic [2:0] K_ER = 3'd6;

    typedef struct packed {
        logic [2:0]  kind;
        logic [7:0]  req;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        wr_valid;
    logic [9:0]  wr_class;
    logic [11:0] wr_offset;
    logic [31:0] wr_data;
    logic        rs_valid;
    logic [31:0] rs_addr;
    logic        ga_valid;
    logic [11:0] ga_offset;
    logic        ga_insert;
    logic        ga_type;
    logic [13:0] ga_count;
    logic [31:0] ga_addr;
    logic        lk_valid;
    logic        lk_release;
    logic [7:0]  lk_index;
    logic        ext_unknown;
    logic        trunc_err;

    int checks = 0;
    int bad = 0;
    bit done = 0;
    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_stream_decoder u_cmd_stream_decoder (
        .clk, .rst, .in_valid, .in_ready, .in_data, .in_last,
        .wr_valid, .wr_class, .wr_offset, .wr_data,
        .rs_valid, .rs_addr,
        .ga_valid, .ga_offset, .ga_insert, .ga_type, .ga_count, .ga_addr,
        .lk_valid, .lk_release, .lk_index, .ext_unknown, .trunc_err
    );

    task automatic push(input logic [2:0] k, input int r, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] c);
        item_t it;
        it.kind = k; it.req = 8'(r); it.a = a; it.b = b; it.c = c;
        exp_q.push_back(it);
    endtask

    task automatic exp_wr(input int r, input logic [9:0] cls, input logic [11:0] ofs, input logic [31:0] d);
        push(K_WR, r, {20'b0, ofs}, d, {22'b0, cls});
    endtask

    task automatic send(input logic [31:0] w, input bit last);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        in_last  = last;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
            in_data  = '0;
        end
    endtask

    task automatic compare(input item_t act);
        item_t e;
        checks++;
        if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R14 unexpected output: actual kind=%0d a=%h b=%h c=%h expected none",
                     act.kind, act.a, act.b, act.c);
        end else begin
            e = exp_q.pop_front();
            if (act.kind != e.kind || act.a != e.a || act.b != e.b || act.c != e.c) begin
                bad++;
                $display("FAIL R%0d actual kind=%0d a=%h b=%h c=%h expected kind=%0d a=%h b=%h c=%h",
                         e.req, act.kind, act.a, act.b, act.c, e.kind, e.a, e.b, e.c);
            end
        end
    endtask

    // monitor: pops the scoreboard as outputs pulse
    always @(negedge clk) begin
        if (!rst) begin
            item_t act;
            if (wr_valid) begin
                act = '0; act.kind = K_WR; act.a = {20'b0, wr_offset}; act.b = wr_data; act.c = {22'b0, wr_class};
                compare(act);
            end
            if (rs_valid) begin
                act = '0; act.kind = K_RS; act.a = rs_addr;
                compare(act);
            end
            if (ga_valid) begin
                act = '0; act.kind = K_GA; act.a = ga_addr;
                act.b = {4'b0, ga_offset, ga_insert, ga_type, ga_count};
                compare(act);
            end
            if (lk_valid) begin
                act = '0; act.kind = K_LK; act.a = {24'b0, lk_index}; act.b = {31'b0, lk_release};
                compare(act);
            end
            if (ext_unknown) begin
                act = '0; act.kind = K_UN;
                compare(act);
            end
            if (trunc_err) begin
                act = '0; act.kind = K_ER;
                compare(act);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R14 watchdog expired: actual running expected finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (wr_valid || rs_valid || ga_valid || lk_valid || ext_unknown || trunc_err) begin
            bad++;
            $display("FAIL R1 pulses in reset: actual %b expected 000000",
                     {wr_valid, rs_valid, ga_valid, lk_valid, ext_unknown, trunc_err});
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (in_ready !== 1'b1 || wr_valid || trunc_err) begin
            bad++;
            $display("FAIL R1 after reset: actual ready=%b wr=%b err=%b expected ready=1 wr=0 err=0",
                     in_ready, wr_valid, trunc_err);
        end

        // R2: class change only, then immediate write uses the new class (R7)
        send({4'h0, 12'h000, 10'h02A, 6'h00}, 0);
        exp_wr(7, 10'h02A, 12'h010, 32'h0000_BEEF);
        send({4'h4, 12'h010, 16'hBEEF}, 0);

        // R3: class set with mask bits 0,3,5
        send({4'h0, 12'h100, 10'h155, 6'b101001}, 0);
        exp_wr(3, 10'h155, 12'h100, 32'h1111_1111); send(32'h1111_1111, 0);
        exp_wr(3, 10'h155, 12'h103, 32'h2222_2222); send(32'h2222_2222, 0);
        exp_wr(3, 10'h155, 12'h105, 32'h3333_3333); send(32'h3333_3333, 0);

        // R4: incrementing across the wrap, with an idle gap (R14)
        send({4'h1, 12'hFFE, 16'd3}, 0);
        exp_wr(4, 10'h155, 12'hFFE, 32'hA0); send(32'hA0, 0);
        exp_wr(4, 10'h155, 12'hFFF, 32'hA1); send(32'hA1, 0);
        idle(2);
        exp_wr(14, 10'h155, 12'h000, 32'hA2); send(32'hA2, 0);

        // R5: fixed offset
        send({4'h2, 12'h020, 16'd2}, 0);
        exp_wr(5, 10'h155, 12'h020, 32'hB0); send(32'hB0, 0);
        exp_wr(5, 10'h155, 12'h020, 32'hB1); send(32'hB1, 0);

        // R6: sparse 16-bit mask
        send({4'h3, 12'h040, 16'h8001}, 0);
        exp_wr(6, 10'h155, 12'h040, 32'hC0); send(32'hC0, 0);
        exp_wr(6, 10'h155, 12'h04F, 32'hC1); send(32'hC1, 0);

        // R12: zero count, next word is a header
        send({4'h1, 12'h050, 16'd0}, 0);
        exp_wr(12, 10'h155, 12'h060, 32'h0000_1234);
        send({4'h4, 12'h060, 16'h1234}, 0);

        // R8: restart
        push(K_RS, 8, 32'h1234_5670, 0, 0);
        send(32'h5123_4567, 0);

        // R9: gather, address word not decoded
        send({4'h6, 12'h0AB, 1'b1, 1'b0, 14'h2345}, 0);
        push(K_GA, 9, 32'hDEAD_BEE0, {4'b0, 12'h0AB, 1'b1, 1'b0, 14'h2345}, 0);
        send(32'hDEAD_BEE0, 0);
        exp_wr(9, 10'h155, 12'h070, 32'h0000_0001);
        send({4'h4, 12'h070, 16'h0001}, 0);

        // R10: lock acquire, release, unknown sub-op
        push(K_LK, 10, 32'h07, 32'h0, 0); send(32'hE000_0007, 0);
        push(K_LK, 10, 32'h81, 32'h1, 0); send(32'hE1FF_FF81, 0);
        push(K_UN, 10, 0, 0, 0);          send(32'hE200_0000, 0);

        // R11: unrecognised opcodes are silent
        send(32'h7FFF_FFFF, 0);
        send(32'hF000_0000, 0);
        send(32'hC000_0001, 0);
        exp_wr(11, 10'h155, 12'h080, 32'h0000_0002);
        send({4'h4, 12'h080, 16'h0002}, 0);

        // R13: stream ends mid-payload
        send({4'h1, 12'h300, 16'd3}, 0);
        exp_wr(13, 10'h155, 12'h300, 32'hD0); send(32'hD0, 0);
        exp_wr(13, 10'h155, 12'h301, 32'hD1);
        push(K_ER, 13, 0, 0, 0);
        send(32'hD1, 1);
        exp_wr(13, 10'h155, 12'h090, 32'h0000_0003);
        send({4'h4, 12'h090, 16'h0003}, 0);

        // R13: gather header is the last word
        push(K_ER, 13, 0, 0, 0);
        send({4'h6, 12'h001, 1'b0, 1'b1, 14'h0004}, 1);
        exp_wr(13, 10'h155, 12'h0A0, 32'h0000_0004);
        send({4'h4, 12'h0A0, 16'h0004}, 0);

        // R13: last word completes the payload, no error
        send({4'h3, 12'h070, 16'h0003}, 0);
        exp_wr(13, 10'h155, 12'h070, 32'hE0); send(32'hE0, 0);
        exp_wr(13, 10'h155, 12'h071, 32'hE1); send(32'hE1, 1);
        exp_wr(13, 10'h155, 12'h0B0, 32'h0000_0005);
        send({4'h4, 12'h0B0, 16'h0005}, 0);

        idle(5);
        checks++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R14 missing outputs: actual pending=%0d expected 0", exp_q.size());
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule